// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block produces the strobes and address/data drive of a multiplexed external memory bus for an 8-bit controller. Each clock is one oscillator period. A machine cycle lasts twelve periods and is built as two halves of six. In a plain code-fetch cycle the address-latch strobe pulses once per half. When the fetch goes to external memory, the active-low program read strobe also pulses once per half. The low port shows the fetch address while the latch strobe is high and is released while the code byte is read in.

The controller can ask for one external data read or write. The request is sampled only at the last phase of a machine cycle, and the whole following machine cycle becomes the data access. In that cycle only one latch pulse is produced and the program read strobe stays idle. A 6-period active-low read or write pulse is placed a fixed distance from the latch edges. The high address port carries either the pointer's high byte or the port-2 latch value, depending on the address mode. A one-phase done pulse ends the access, and the byte read is kept on a data output.

Top module: `xbus_seq`

## Requirements
- R1: While `rst` is high and directly after it: `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `lo_oe`=0, `done`=0. The first rising edge after `rst` falls starts phase 0 of a machine cycle (phases 0..11).
- R2: In a fetch cycle `ale` is high in phases 0, 1, 6 and 7 and low in the other phases, whether the fetch is internal or external.
- R3: For an external fetch, `psen_n` is low in phases 3..5 and 9..11. `lo_oe`=1 and `lo_out`=`pc[7:0]` in the `ale` phases, and `lo_oe`=0 in the rest. `hi_out`=`pc[15:8]` for the whole cycle. `pc` is sampled on the edges that end phases 5 and 11.
- R4: With `ext_strap`=0 every fetch is external. With `ext_strap`=1 a fetch is external only when `pc` > `INT_LIMIT` (default 16'h0FFF). An internal fetch keeps `psen_n`=1 and `lo_oe`=0, and `hi_out` follows `p2_latch`.
- R5: A request with `req_valid`=1 on the edge ending phase 11 turns the next machine cycle into a data cycle. In that cycle `ale` is high only in phases 0..1 (the phase 6..7 pulse is omitted) and `psen_n` stays 1 in all twelve phases.
- R6: In a read (`req_write`=0) or write (`req_write`=1) cycle, `rd_n` or `wr_n` is low in phases 5..10 only (6 periods). It falls 3 periods after `ale` falls, and `ale` rises 1 period after it rises.
- R7: In a data cycle `hi_out` = `req_addr[15:8]` when `req_wide`=1, and the `p2_latch` value sampled with the request when `req_wide`=0.
- R8: In a data cycle the low port drives `req_addr[7:0]` in phases 0..1. For a write it drives `req_wdata` with `lo_oe`=1 in phases 2..11. For a read `lo_oe`=0 and `lo_out`=0 in phases 2..11.
- R9: A read takes `lo_in` in phase 10 and shows it on `rd_data` from phase 11. `rd_data` holds this value through later writes and fetches until the next read.
- R10: `done` is 1 in phase 11 of a data cycle and 0 at all other times.
- R11: `req_valid` high on any edge other than the one ending phase 11 is ignored, and the next cycle stays a fetch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one period per phase |
| rst | input | 1 | Synchronous active-high reset |
| pc | input | 16 | Program counter, fetch address |
| ext_strap | input | 1 | 0: all code external; 1: external only above INT_LIMIT |
| p2_latch | input | 8 | Port-2 latch value |
| req_valid | input | 1 | Data access request, sampled at phase 11 |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1: 16-bit pointer address; 0: 8-bit register-indirect |
| req_addr | input | 16 | Data address |
| req_wdata | input | 8 | Write data |
| lo_in | input | 8 | Low port input from the bus |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| lo_out | output | 8 | Low port drive value (address/data) |
| lo_oe | output | 1 | Low port output enable |
| hi_out | output | 8 | High address port |
| rd_data | output | 8 | Last byte read |
| done | output | 1 | Data access ends this phase |

## Verification
The assertions take for granted that `req_valid` is high for no more than one edge per request and that the request fields and `pc` do not change at the edges where they are sampled. The stimulus meets these conditions. It drives every input on the falling edge and follows its own phase count. It raises `req_valid` only for the edge that ends phase 11, except in the one deliberate off-boundary pulse, and it holds `pc` and `lo_in` fixed for a whole machine cycle. Under these conditions the checks on strobe spacing, the single latch pulse and the low port direction during a read or write are expected to hold for every access the bench performs.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int PH_PER_MC = 12;
    localparam int PH_W      = $clog2(PH_PER_MC);

    typedef logic [PH_W-1:0]   phase_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    localparam phase_t LAST_PH   = phase_t'(PH_PER_MC - 1);
    localparam phase_t HALF      = phase_t'(PH_PER_MC / 2);
    localparam phase_t HALF_LAST = phase_t'(PH_PER_MC / 2 - 1);
    localparam phase_t ALE_LEN   = phase_t'(2);
    localparam phase_t PSEN_OFS  = phase_t'(3);
    localparam phase_t STB_FIRST = phase_t'(5);
    localparam phase_t STB_LAST  = phase_t'(10);

    typedef enum logic [1:0] {CYC_FETCH, CYC_READ, CYC_WRITE} cyc_e;

    typedef struct packed {
        cyc_e  kind;
        addr_t addr;
        byte_t wdata;
        byte_t hi_sel;
    } xreq_t;

    typedef struct packed {
        logic  ext;
        addr_t addr;
    } fetch_t;

    function automatic phase_t half_ph(phase_t p);
        return (p >= HALF) ? p - HALF : p;
    endfunction
endpackage

// File: rtl/xbus_phase.sv
module xbus_phase
    import xbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t ph,
    output logic   mc_end,
    output logic   half_end
);
    always_ff @(posedge clk) begin
        if (rst)         ph <= LAST_PH;
        else if (mc_end) ph <= '0;
        else             ph <= ph + 1'b1;
    end

    assign mc_end   = (ph == LAST_PH);
    assign half_end = mc_end || (ph == HALF_LAST);

    // R1
    ph_range_chk: assert property (@(posedge clk) disable iff (rst) ph <= LAST_PH);
    // R2
    ph_wrap_chk: assert property (@(posedge clk) disable iff (rst) mc_end |=> ph == '0);
    // R2
    ph_step_chk: assert property (@(posedge clk) disable iff (rst)
        !mc_end |=> ph == $past(ph) + 1'b1);
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture
    import xbus_pkg::*;
#(
    parameter addr_t INT_LIMIT = 16'h0FFF
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   mc_end,
    input  logic   half_end,
    input  logic   req_valid,
    input  logic   req_write,
    input  logic   req_wide,
    input  addr_t  req_addr,
    input  byte_t  req_wdata,
    input  byte_t  p2_latch,
    input  addr_t  pc,
    input  logic   ext_strap,
    output xreq_t  cur,
    output fetch_t fet
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur.kind   <= CYC_FETCH;
            cur.addr   <= '0;
            cur.wdata  <= '0;
            cur.hi_sel <= '0;
        end else if (mc_end) begin
            if (req_valid) begin
                cur.kind   <= req_write ? CYC_WRITE : CYC_READ;
                cur.addr   <= req_addr;
                cur.wdata  <= req_wdata;
                cur.hi_sel <= req_wide ? req_addr[ADDR_W-1 -: DATA_W] : p2_latch;
            end else begin
                cur.kind <= CYC_FETCH;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fet <= '0;
        end else if (half_end) begin
            fet.ext  <= !ext_strap || (pc > INT_LIMIT);
            fet.addr <= pc;
        end
    end

    // R11
    kind_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mc_end |=> $stable(cur.kind));
endmodule

// File: rtl/xbus_strobe.sv
module xbus_strobe
    import xbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t ph,
    input  xreq_t  cur,
    input  fetch_t fet,
    input  byte_t  p2_latch,
    input  byte_t  lo_in,
    output logic   ale,
    output logic   psen_n,
    output logic   rd_n,
    output logic   wr_n,
    output byte_t  lo_out,
    output logic   lo_oe,
    output byte_t  hi_out,
    output byte_t  rd_data,
    output logic   done
);
    logic   is_data, is_wr, addr_slot, ale_slot, stb_win;
    phase_t hp;

    always_comb begin
        hp        = half_ph(ph);
        is_data   = (cur.kind != CYC_FETCH);
        is_wr     = (cur.kind == CYC_WRITE);
        addr_slot = (ph < ALE_LEN);
        ale_slot  = (hp < ALE_LEN);
        stb_win   = (ph >= STB_FIRST) && (ph <= STB_LAST);

        ale    = is_data ? addr_slot : ale_slot;
        psen_n = !(!is_data && fet.ext && (hp >= PSEN_OFS));
        rd_n   = !((cur.kind == CYC_READ) && stb_win);
        wr_n   = !(is_wr && stb_win);
        done   = is_data && (ph == LAST_PH);

        if (is_data) begin
            lo_oe  = addr_slot || is_wr;
            lo_out = addr_slot ? cur.addr[DATA_W-1:0] : (is_wr ? cur.wdata : '0);
            hi_out = cur.hi_sel;
        end else begin
            lo_oe  = fet.ext && ale_slot;
            lo_out = lo_oe ? fet.addr[DATA_W-1:0] : '0;
            hi_out = fet.ext ? fet.addr[ADDR_W-1 -: DATA_W] : p2_latch;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                        rd_data <= '0;
        else if (cur.kind == CYC_READ && ph == STB_LAST) rd_data <= lo_in;
    end

    // R6
    stb_after_ale_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(rd_n) || $fell(wr_n)) |-> ($past(ale, 4) && !$past(ale, 3) && !ale));
    // R6
    ale_after_stb_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ale) && !$past(rd_n && wr_n, 2)) |-> $past(rd_n && wr_n));
    // R5
    stb_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> (psen_n && !ale && (rd_n != wr_n)));
    // R8
    rd_release_chk: assert property (@(posedge clk) disable iff (rst) !rd_n |-> !lo_oe);
    // R8
    wr_drive_chk: assert property (@(posedge clk) disable iff (rst) !wr_n |-> lo_oe);
    // R10
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (rd_n && wr_n && !$past(rd_n && wr_n)));
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter addr_t INT_LIMIT = 16'h0FFF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   pc,
    input  logic                ext_strap,
    input  logic [DATA_W-1:0]   p2_latch,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_wide,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W-1:0]   lo_in,
    output logic                ale,
    output logic                psen_n,
    output logic                rd_n,
    output logic                wr_n,
    output logic [DATA_W-1:0]   lo_out,
    output logic                lo_oe,
    output logic [DATA_W-1:0]   hi_out,
    output logic [DATA_W-1:0]   rd_data,
    output logic                done
);
    phase_t ph;
    logic   mc_end, half_end;
    xreq_t  cur;
    fetch_t fet;

    xbus_phase u_phase (
        .clk(clk), .rst(rst), .ph(ph), .mc_end(mc_end), .half_end(half_end)
    );

    xbus_capture #(.INT_LIMIT(INT_LIMIT)) u_cap (
        .clk(clk), .rst(rst), .mc_end(mc_end), .half_end(half_end),
        .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata), .p2_latch(p2_latch),
        .pc(pc), .ext_strap(ext_strap), .cur(cur), .fet(fet)
    );

    xbus_strobe u_stb (
        .clk(clk), .rst(rst), .ph(ph), .cur(cur), .fet(fet),
        .p2_latch(p2_latch), .lo_in(lo_in),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out),
        .rd_data(rd_data), .done(done)
    );
endmodule

// File: tb/sim_xbus_seq.sv
`timescale 1ns/1ps
module sim_xbus_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pc = '0;
    logic        ext_strap = 1'b1;
    logic [7:0]  p2_latch = '0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0, lo_in = '0;
    logic        ale, psen_n, rd_n, wr_n, lo_oe, done;
    logic [7:0]  lo_out, hi_out, rd_data;

    int checks = 0, fails = 0, bph = 11;
    bit finished = 1'b0;
    logic [7:0] last_rd = 8'h00;

    always #4 clk = ~clk;

    xbus_seq u0 (
        .clk(clk), .rst(rst), .pc(pc), .ext_strap(ext_strap), .p2_latch(p2_latch),
        .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata), .lo_in(lo_in),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .lo_out(lo_out),
        .lo_oe(lo_oe), .hi_out(hi_out), .rd_data(rd_data), .done(done)
    );

    // bench-side phase model: 12 phases, reset parks at 11
    always @(posedge clk) begin
        if (rst) bph <= 11;
        else     bph <= (bph == 11) ? 0 : bph + 1;
    end

    typedef struct packed {
        logic        wr;
        logic        wide;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  p2;
        logic [7:0]  bus;
        logic [7:0]  exp_hi;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 16'h12A5, 8'h00, 8'h3C, 8'h5A, 8'h12},
        '{1'b1, 1'b1, 16'hBEEF, 8'hC3, 8'h77, 8'h00, 8'hBE},
        '{1'b0, 1'b0, 16'h0044, 8'h00, 8'h9E, 8'hE1, 8'h9E},
        '{1'b1, 1'b0, 16'hFF80, 8'h5D, 8'h21, 8'h00, 8'h21},
        '{1'b0, 1'b1, 16'hFFFF, 8'h00, 8'h00, 8'hFF, 8'hFF}
    };

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s phase %0d: actual %h expected %h", req, what, bph, act, exp);
        end
    endtask

    task automatic wait_ph(input int p);
        do @(negedge clk); while (bph != p);
    endtask

    task automatic run_access(input vec_t v);
        wait_ph(11);
        req_valid = 1'b1; req_write = v.wr; req_wide = v.wide;
        req_addr = v.addr; req_wdata = v.wdata; p2_latch = v.p2; lo_in = v.bus;
        @(negedge clk);
        req_valid = 1'b0;
        p2_latch = ~v.p2;  // later changes must not reach hi_out (R7)
        if (!v.wr) last_rd = v.bus;
        for (int i = 0; i < 12; i++) begin
            logic stb;
            stb = (i >= 5 && i <= 10);
            chk("R5", "ale", ale, i < 2);
            chk("R5", "psen_n", psen_n, 1);
            chk("R6", "rd_n", rd_n, !(!v.wr && stb));
            chk("R6", "wr_n", wr_n, !(v.wr && stb));
            chk("R8", "lo_oe", lo_oe, (i < 2) || v.wr);
            chk("R8", "lo_out", lo_out,
                (i < 2) ? v.addr[7:0] : (v.wr ? v.wdata : 8'h00));
            chk("R7", "hi_out", hi_out, v.exp_hi);
            chk("R10", "done", done, i == 11);
            if (i == 11) chk("R9", "rd_data", rd_data, last_rd);
            @(negedge clk);
        end
    endtask

    task automatic run_fetch(input logic [15:0] a, input logic strap,
                             input logic [7:0] p2, input logic ext, input string req);
        wait_ph(11);
        pc = a; ext_strap = strap; p2_latch = p2;
        @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            int  h;
            logic slot;
            h = (i >= 6) ? i - 6 : i;
            slot = (h < 2);
            chk("R2", "ale", ale, slot);
            chk(req, "psen_n", psen_n, !(ext && h >= 3));
            chk(req, "lo_oe", lo_oe, ext && slot);
            chk(req, "lo_out", lo_out, (ext && slot) ? a[7:0] : 8'h00);
            chk(req, "hi_out", hi_out, ext ? a[15:8] : p2);
            chk("R10", "done", done, 0);
            chk("R9", "rd_data", rd_data, last_rd);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "ale", ale, 0);
        chk("R1", "psen_n", psen_n, 1);
        chk("R1", "rd_n", rd_n, 1);
        chk("R1", "wr_n", wr_n, 1);
        chk("R1", "lo_oe", lo_oe, 0);
        chk("R1", "done", done, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ale at phase 0", ale, 1);

        // external fetches with strap low, then the strap boundary
        run_fetch(16'h3456, 1'b0, 8'hAA, 1'b1, "R3");
        run_fetch(16'h0001, 1'b0, 8'hAA, 1'b1, "R4");
        run_fetch(16'h0FFF, 1'b1, 8'h6B, 1'b0, "R4");
        run_fetch(16'h1000, 1'b1, 8'h6B, 1'b1, "R4");

        // table of data accesses
        for (int k = 0; k < NV; k++) run_access(VECS[k]);

        // back to fetching after an access
        run_fetch(16'hC0DE, 1'b0, 8'h11, 1'b1, "R3");

        // R11: off-boundary request ignored
        ext_strap = 1'b0; pc = 16'h2222;
        wait_ph(4);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h5555; req_wdata = 8'h99;
        @(negedge clk);
        req_valid = 1'b0;
        wait_ph(11);
        @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            chk("R11", "wr_n", wr_n, 1);
            chk("R11", "rd_n", rd_n, 1);
            chk("R11", "ale", ale, (i < 2) || (i == 6) || (i == 7));
            chk("R11", "done", done, 0);
            @(negedge clk);
        end

        // R1: reset in the middle of an access
        wait_ph(11);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0102;
        @(negedge clk);
        req_valid = 1'b0;
        wait_ph(6);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "rd_n in reset", rd_n, 1);
        chk("R1", "lo_oe in reset", lo_oe, 0);
        chk("R1", "done in reset", done, 0);
        chk("R1", "ale in reset", ale, 0);
        rst = 1'b0;

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule